// File: doc/BRIEF.md
# Multi-Latency Issue Controller

This block sits at the issue stage of a pipeline that feeds four execution resources. An integer unit takes one cycle. A pipelined add unit takes four cycles and a pipelined multiply unit takes seven. A divider with no internal pipelining takes twenty-four. Each cycle the upstream stage offers one decoded operation, made up of a unit code, a destination register and two source registers. It holds that operation steady until the controller accepts it. The controller accepts the operation only when no stall reason applies. There are four reasons: the divider is occupied, a read-after-write hazard exists on a result that is still in flight, the single write-back port is already booked for the cycle in which the new result would arrive, or exception-safe mode is on and an older operation that may still raise an exception has not yet reached write-back.

The units are modelled only as latency pipelines carrying tags. Every accepted operation receives a sequence number. Its tag holds that number, its unit code and its destination. The tag is written into a reservation vector of tags that shifts by one slot each cycle, and the slot index equals the cycles left until the result appears. The head slot drives the write-back outputs. Because the latencies differ, a younger operation can finish before an older one.

Top module: `fpi_issue_ctrl`

## Requirements
- R1: Unit codes are 0 integer, 1 add, 2 multiply, 3 divide. An operation of latency L (1, 4, 7 or 24 for those codes) accepted on clock edge n is shown on the write-back outputs, with its unit code, destination and sequence number, during the cycle between edges n+L-1 and n+L.
- R2: The add and multiply units accept a new operation on every clock edge when no other stall reason applies.
- R3: A divide that is offered while an earlier divide is occupying the divider is accepted exactly 24 edges after the earlier one.
- R4: Results may leave out of order. A short operation issued after a long one reaches write-back first, carrying its own tag.
- R5: An operation whose result would arrive in a cycle already booked for another result is held. It is accepted on the first edge where its arrival cycle is free.
- R6: An operation is held while either source register equals the destination of an accepted operation that has not yet reached write-back. It is accepted on the edge that ends the producer's write-back cycle.
- R7: When safe_mode is high, an add, multiply or divide in flight holds all later issue until that operation is on the write-back outputs. When safe_mode is low, this hold does not apply.
- R8: Integer operations never raise this hold, so a stream of integer operations issues on every edge in safe mode.
- R9: Sequence numbers start at 0 after reset, step by one per accepted operation, and wrap after 15.
- R10: Reset empties every in-flight slot and frees the divider. After reset no write-back appears, in_ready is high for an integer operation, and issue_seq is 0.
- R11: While in_valid is low, nothing is accepted. The sequence number is unchanged and no later write-back appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| safe_mode | input | 1 | Hold issue behind operations that may raise exceptions |
| in_valid | input | 1 | An operation is offered |
| in_unit | input | 2 | Unit code of the offered operation |
| in_dst | input | 5 | Destination register |
| in_src_a | input | 5 | First source register |
| in_src_b | input | 5 | Second source register |
| in_ready | output | 1 | No stall reason applies to the offered operation |
| issue | output | 1 | Operation accepted on this edge |
| issue_seq | output | 4 | Sequence number given to the next accepted operation |
| wb_valid | output | 1 | A result occupies the write-back port |
| wb_unit | output | 2 | Unit code of that result |
| wb_dst | output | 5 | Destination of that result |
| wb_seq | output | 4 | Sequence number of that result |

## Verification
Single isolated operations of each unit type fix the latency of each path and the contents of the tag. Back-to-back multiplies separate a pipelined unit from a blocking one, and two divides in a row measure how long the divider stays occupied. A multiply followed by an add placed to land on the same cycle tells a write-port clash apart from a plain latency delay. A dependent integer operation, and the same independent integer operation offered with safe_mode high and then low, tell the register hazard apart from the exception hold. Long integer streams cover sequence wrap-around and show that the hold is never raised by an integer operation.

// File: rtl/fpi_pkg.sv
package fpi_pkg;
  parameter int REG_AW = 5;
  parameter int SEQ_W  = 4;

  typedef enum logic [1:0] {
    U_INT = 2'd0,
    U_ADD = 2'd1,
    U_MUL = 2'd2,
    U_DIV = 2'd3
  } unit_e;

  typedef struct packed {
    logic              vld;
    logic              may_exc;
    unit_e             unit;
    logic [REG_AW-1:0] dst;
    logic [SEQ_W-1:0]  seq;
  } tag_t;

  // cycles from acceptance until the result occupies the write-back port
  function automatic int unsigned lat_of(unit_e u, int unsigned add_l,
                                         int unsigned mul_l, int unsigned div_l);
    case (u)
      U_INT:   return 1;
      U_ADD:   return add_l;
      U_MUL:   return mul_l;
      default: return div_l;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/fpi_resv_shift.sv
module fpi_resv_shift
  import fpi_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  tag_t                 wr_tag,
  output tag_t [DEPTH-1:0]     slots
);
  tag_t [DEPTH-1:0] slots_q;
  tag_t [DEPTH-1:0] slots_d;
  logic             landing_busy;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      slots_d[k] = (k == DEPTH-1) ? tag_t'('0) : slots_q[(k+1) % DEPTH];
      if (wr_en && wr_idx == IDX_W'(k)) slots_d[k] = wr_tag;
    end
  end

  // a write landing where a shifted result already sits
  always_comb begin
    landing_busy = 1'b0;
    for (int k = 0; k < DEPTH-1; k++)
      if (wr_en && wr_idx == IDX_W'(k) && slots_q[k+1].vld) landing_busy = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slots_q <= '0;
    else        slots_q <= slots_d;
  end

  assign slots = slots_q;

  p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n) !landing_busy)
    else $error("write-back slot booked twice");

  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slots_q[1].vld |=> slots_q[0].vld && slots_q[0].seq == $past(slots_q[1].seq))
    else $error("tag did not advance toward write-back");
endmodule

// File: rtl/fpi_div_track.sv
module fpi_div_track #(
  parameter int DIV_LAT = 24,
  localparam int CW = $clog2(DIV_LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CW'(DIV_LAT - 1);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  p_div_idle_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> cnt_q == '0)
    else $error("divide started while divider occupied");
endmodule

// File: rtl/fpi_hazard.sv
module fpi_hazard
  import fpi_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int LAT_W = $clog2(DEPTH + 1)
) (
  input  tag_t [DEPTH-1:0]  slots,
  input  logic [LAT_W-1:0]  new_lat,
  input  logic [REG_AW-1:0] src_a,
  input  logic [REG_AW-1:0] src_b,
  input  logic              safe_mode,
  output logic              wb_clash,
  output logic              raw_hit,
  output logic              exc_hold
);
  logic [DEPTH-1:0] clash_v, raw_v, exc_v;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    // slot k+... shifts to k-1 on the edge, so slot L meets a new write at L-1
    assign clash_v[k] = slots[k].vld && (new_lat == LAT_W'(k));
    if (k == 0) begin : g_head
      // head slot is on the write-back port: counted as finished
      assign raw_v[k] = 1'b0;
      assign exc_v[k] = 1'b0;
    end else begin : g_tail
      assign raw_v[k] = slots[k].vld && (slots[k].dst == src_a || slots[k].dst == src_b);
      assign exc_v[k] = safe_mode && slots[k].vld && slots[k].may_exc;
    end
  end

  assign wb_clash = |clash_v;
  assign raw_hit  = |raw_v;
  assign exc_hold = |exc_v;
endmodule

// File: rtl/fpi_issue_ctrl.sv
module fpi_issue_ctrl
  import fpi_pkg::*;
#(
  parameter int         ADD_LAT  = 4,
  parameter int         MUL_LAT  = 7,
  parameter int         DIV_LAT  = 24,
  parameter logic [3:0] EXC_MASK = 4'b1110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              safe_mode,
  input  logic              in_valid,
  input  logic [1:0]        in_unit,
  input  logic [REG_AW-1:0] in_dst,
  input  logic [REG_AW-1:0] in_src_a,
  input  logic [REG_AW-1:0] in_src_b,
  output logic              in_ready,
  output logic              issue,
  output logic [SEQ_W-1:0]  issue_seq,
  output logic              wb_valid,
  output logic [1:0]        wb_unit,
  output logic [REG_AW-1:0] wb_dst,
  output logic [SEQ_W-1:0]  wb_seq
);
  localparam int DEPTH = int'(max3(ADD_LAT, MUL_LAT, DIV_LAT));
  localparam int LAT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  unit_e              unit;
  logic [LAT_W-1:0]   new_lat;
  logic [IDX_W-1:0]   wr_idx;
  tag_t               wr_tag;
  tag_t [DEPTH-1:0]   slots;
  logic               div_busy, div_block, wb_clash, raw_hit, exc_hold, stall;
  logic [SEQ_W-1:0]   seq_q;

  assign unit    = unit_e'(in_unit);
  assign new_lat = LAT_W'(lat_of(unit, ADD_LAT, MUL_LAT, DIV_LAT));
  assign wr_idx  = IDX_W'(new_lat - LAT_W'(1));

  always_comb begin
    wr_tag.vld     = 1'b1;
    wr_tag.may_exc = EXC_MASK[in_unit];
    wr_tag.unit    = unit;
    wr_tag.dst     = in_dst;
    wr_tag.seq     = seq_q;
  end

  fpi_hazard #(.DEPTH(DEPTH)) hazard_i (
    .slots    (slots),
    .new_lat  (new_lat),
    .src_a    (in_src_a),
    .src_b    (in_src_b),
    .safe_mode(safe_mode),
    .wb_clash (wb_clash),
    .raw_hit  (raw_hit),
    .exc_hold (exc_hold)
  );

  fpi_div_track #(.DIV_LAT(DIV_LAT)) div_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(issue && unit == U_DIV),
    .busy (div_busy)
  );

  assign div_block = div_busy && unit == U_DIV;
  assign stall     = div_block | wb_clash | raw_hit | exc_hold;
  assign in_ready  = !stall;
  assign issue     = in_valid && in_ready;

  fpi_resv_shift #(.DEPTH(DEPTH)) resv_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (issue),
    .wr_idx(wr_idx),
    .wr_tag(wr_tag),
    .slots (slots)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seq_q <= '0;
    else if (issue) seq_q <= seq_q + 1'b1;
  end

  assign issue_seq = seq_q;
  assign wb_valid  = slots[0].vld;
  assign wb_unit   = slots[0].unit;
  assign wb_dst    = slots[0].dst;
  assign wb_seq    = slots[0].seq;

  p_seq_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> issue_seq == $past(issue_seq) + SEQ_W'(1))
    else $error("sequence did not step");

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(issue_seq))
    else $error("sequence moved while idle");
endmodule

// File: tb/fpi_issue_ctrl_tb_top.sv
module fpi_issue_ctrl_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, safe_mode = 1'b0, in_valid = 1'b0;
  logic [1:0] in_unit = 2'd0;
  logic [4:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic       in_ready, issue, wb_valid;
  logic [3:0] issue_seq, wb_seq;
  logic [1:0] wb_unit;
  logic [4:0] wb_dst;

  fpi_issue_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .safe_mode(safe_mode), .in_valid(in_valid),
    .in_unit(in_unit), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_ready(in_ready), .issue(issue), .issue_seq(issue_seq),
    .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_dst(wb_dst), .wb_seq(wb_seq)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  int log_n = 0;
  int log_cyc[64], log_seq[64], log_dst[64], log_unit[64];
  always @(negedge clk) begin
    #1;
    if (rst_n && wb_valid && log_n < 64) begin
      log_cyc[log_n] = cyc; log_seq[log_n] = int'(wb_seq);
      log_dst[log_n] = int'(wb_dst); log_unit[log_n] = int'(wb_unit);
      log_n++;
    end
  end

  task automatic chk(string rq, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int wb_idx(int seq);
    for (int i = 0; i < log_n; i++) if (log_seq[i] == seq) return i;
    return -1;
  endfunction

  function automatic int wb_cyc(int seq);
    int i = wb_idx(seq);
    return (i < 0) ? -1 : log_cyc[i];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; safe_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; log_n = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // starts and ends at a falling edge; at = count of rising edges at acceptance
  task automatic offer(input int u, input int d, input int sa, input int sb,
                       output int at, output int waited);
    in_valid = 1'b1; in_unit = u[1:0]; in_dst = d[4:0];
    in_src_a = sa[4:0]; in_src_b = sb[4:0]; waited = 0;
    #1;
    while (!issue) begin @(negedge clk); #1; waited++; end
    @(posedge clk); @(negedge clk);
    at = cyc; in_valid = 1'b0;
  endtask

  task automatic t_reset();
    int a, w;
    do_reset(); #1;
    chk("R10", "wb_valid after reset", int'(wb_valid), 0);
    chk("R10", "in_ready after reset", int'(in_ready), 1);
    chk("R10", "issue_seq after reset", int'(issue_seq), 0);
    offer(2, 3, 30, 31, a, w);
    do_reset(); idle(10);
    chk("R10", "write-back of flushed multiply", log_n, 0);
  endtask

  task automatic t_latency();
    int e1, e2, e3, w;
    do_reset();
    offer(0, 1, 30, 31, e1, w); idle(2);
    offer(1, 2, 30, 31, e2, w); idle(6);
    offer(2, 3, 30, 31, e3, w); idle(10);
    chk("R1", "integer wb cycle", wb_cyc(0), e1);
    chk("R1", "add wb cycle", wb_cyc(1), e2 + 3);
    chk("R1", "multiply wb cycle", wb_cyc(2), e3 + 6);
    chk("R1", "add wb dst", (wb_idx(1) < 0) ? -1 : log_dst[wb_idx(1)], 2);
    chk("R1", "multiply wb unit code", (wb_idx(2) < 0) ? -1 : log_unit[wb_idx(2)], 2);
    chk("R1", "write-back count", log_n, 3);
  endtask

  task automatic t_pipelined();
    int e1, e2, e3, w1, w2, w3;
    do_reset();
    offer(2, 4, 30, 31, e1, w1);
    offer(2, 5, 30, 31, e2, w2);
    offer(1, 6, 30, 31, e3, w3);
    idle(10);
    chk("R2", "second multiply edge", e2, e1 + 1);
    chk("R2", "add after multiplies edge", e3, e2 + 1);
    chk("R2", "second multiply wb", wb_cyc(1), e1 + 7);
  endtask

  task automatic t_divide();
    int e1, e2, w;
    do_reset();
    offer(3, 7, 30, 31, e1, w);
    offer(3, 8, 30, 31, e2, w);
    chk("R3", "second divide edge", e2, e1 + 24);
    chk("R3", "second divide stall cycles", w, 23);
    idle(26);
    chk("R3", "first divide wb", wb_cyc(0), e1 + 23);
    chk("R3", "second divide wb", wb_cyc(1), e2 + 23);
  endtask

  task automatic t_out_of_order();
    int e1, e2, w;
    do_reset();
    offer(2, 9, 30, 31, e1, w);
    offer(0, 10, 30, 31, e2, w);
    idle(8);
    chk("R4", "integer accepted next edge", e2, e1 + 1);
    chk("R4", "younger result leaves first", int'(wb_cyc(1) < wb_cyc(0)), 1);
    chk("R4", "first write-back tag", log_seq[0], 1);
    chk("R4", "first write-back dst", log_dst[0], 10);
  endtask

  task automatic t_clash();
    int e1, e2, w;
    do_reset();
    offer(2, 11, 30, 31, e1, w); idle(2);
    offer(1, 12, 30, 31, e2, w);
    idle(8);
    chk("R5", "clashing add edge", e2, e1 + 4);
    chk("R5", "clashing add stall cycles", w, 1);
    chk("R5", "add wb after multiply", wb_cyc(1), e1 + 7);
  endtask

  task automatic t_raw();
    int e1, e2, w;
    do_reset();
    offer(1, 13, 30, 31, e1, w);
    offer(0, 14, 29, 13, e2, w);
    idle(3);
    chk("R6", "dependent edge", e2, e1 + 4);
    chk("R6", "dependent issues after producer wb", e2, wb_cyc(0) + 1);
  endtask

  task automatic t_safe();
    int e1, e2, w;
    do_reset(); safe_mode = 1'b1;
    offer(1, 15, 30, 31, e1, w);
    offer(0, 16, 28, 29, e2, w);
    idle(3);
    chk("R7", "safe mode held independent op", e2, e1 + 4);
    do_reset(); safe_mode = 1'b0;
    offer(1, 15, 30, 31, e1, w);
    offer(0, 16, 28, 29, e2, w);
    idle(6);
    chk("R7", "normal mode independent op", e2, e1 + 1);
    do_reset(); safe_mode = 1'b1;
    offer(0, 1, 30, 31, e1, w);
    offer(0, 2, 30, 31, e2, w);
    chk("R8", "integer stream in safe mode", e2, e1 + 1);
    offer(0, 3, 30, 31, e1, w);
    chk("R8", "third integer stall cycles", w, 0);
    safe_mode = 1'b0;
  endtask

  task automatic t_idle();
    do_reset();
    in_unit = 2'd0; in_dst = 5'd5; in_src_a = 5'd30; in_src_b = 5'd31;
    idle(5); #1;
    chk("R11", "issue_seq while idle", int'(issue_seq), 0);
    chk("R11", "write-back while idle", log_n, 0);
  endtask

  task automatic t_wrap();
    int e, w, bad;
    do_reset();
    for (int k = 0; k < 17; k++) offer(0, (k % 8) + 1, 30, 31, e, w);
    idle(2);
    chk("R9", "write-back count in stream", log_n, 17);
    bad = 0;
    for (int i = 0; i < log_n; i++) if (log_seq[i] != (i % 16)) bad++;
    chk("R9", "tags out of order", bad, 0);
    chk("R9", "wrapped tag", log_seq[16], 0);
    chk("R9", "issue_seq after 17", int'(issue_seq), 1);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_pipelined();
    t_divide();
    t_out_of_order();
    t_clash();
    t_raw();
    t_safe();
    t_idle();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule